// File: doc/BRIEF.md
# Seventeen-Level Noise-Shaping Modulator with Triangular Dither

This block turns one channel of oversampled two's-complement audio into a stream of quantiser codes from 0 to 16. Each code selects one of seventeen evenly spaced output levels, with one sixteenth of the full range between neighbours. Samples arrive with a one-cycle strobe at 128 times the audio sample rate. Each strobe yields one code one clock later.

The loop shapes its error with a second-order error-feedback filter whose noise transfer function is (1 − z⁻¹)². Quantisation error is pushed out of the audio band, and the long-run mean of the output tracks the input. Triangular-PDF dither can be added in front of the quantiser. It is the difference of two uniform values, each drawn from its own maximal-length shift register. A mute input replaces the sample with zero while the loop keeps running, so the output does not step abruptly. For stereo, instantiate the block twice.

Top module: `msdm_core`

## Requirements
- R1: Reset is synchronous and active low. After reset, `out_valid` is 0, `out_code` is 8, both stored errors are zero and both dither registers are back at their seeds.
- R2: `out_valid` is high in exactly the cycle after each cycle with `in_valid` high. `out_code` changes only in those cycles and holds its value otherwise.
- R3: `out_code` is never above 16.
- R4: With dither off, each strobe computes w = x − 2·e1 + e2, where x is the sample and e1, e2 are the last two stored errors. The code is clamp(floor((w + 2^13) / 2^14) + 8, 0, 16). The stored error becomes (code − 8)·2^14 − w, saturated to ±2^15, and it is shifted into e1 while the old e1 moves to e2.
- R5: A zero input with dither off gives code 8 on every strobe from reset.
- R6: For a constant input x with |x| ≤ 2^15, over N strobes from reset the sum of (code − 8)·2^14 differs from N·x by at most 4·2^15, with dither on or off.
- R7: With `dither_en` high, a value in (−2^14, 2^14) is added to w before quantising and is included in the stored error. With zero input from reset, every code lies in 2..14 and not every code is 8.
- R8: While `mute` is high, the loop behaves exactly as if the sample were zero, and it continues from whatever error state it already holds.
- R9: Full-scale inputs (+131071 or −131072) clamp the code at 16 or 0 without wrapping, and the result follows the R4 rule including error saturation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe marking a new oversampled sample |
| in_sample | input | 18 | Signed two's-complement sample |
| mute | input | 1 | Replaces the sample with zero; the loop keeps running |
| dither_en | input | 1 | Adds triangular dither before the quantiser |
| out_valid | output | 1 | High in the cycle after a strobe |
| out_code | output | 5 | Quantiser code, 0 to 16 |

## Verification
Every code is due exactly one clock after the strobe that produced it. `out_valid` is high only in that cycle.

The bench drives a strobe on a falling edge, lowers the strobe at the next falling edge, and checks `out_valid` and the code there. It then walks through a random gap of idle cycles, checking at each one that `out_valid` is low and the code has not moved.

With dither off, the codes are compared one by one against a bench function that follows the R4 rule. With dither on, the checks are on the range of the codes and on the running sum over 1024 strobes, which is read only after the last code has arrived.

// File: rtl/sdm_pkg.sv
// Shared constants for the seventeen-level modulator.
// Assumes an 18-bit sample and a 16-step quantiser range.
package sdm_pkg;
    localparam int SDM_IN_W      = 18;
    localparam int SDM_LEVELS    = 17;
    localparam int SDM_CODE_W    = $clog2(SDM_LEVELS);
    localparam int SDM_MID       = (SDM_LEVELS - 1) / 2;
    localparam int SDM_STEP_LOG2 = SDM_IN_W - $clog2(SDM_LEVELS - 1);
    localparam int SDM_ACC_W     = SDM_IN_W + 4;

    typedef logic [SDM_CODE_W-1:0] sdm_code_t;
endpackage

// File: rtl/sdm_lfsr.sv
// Fibonacci maximal-length shift register.
// It advances STEPS bits on each advance pulse and exposes its low OUT_W bits as a uniform value.
// Assumes SEED is nonzero and that LEN/TAP form a maximal polynomial.
module sdm_lfsr #(
    parameter int          LEN   = 31,
    parameter int          TAP   = 28,
    parameter int          STEPS = 14,
    parameter int          OUT_W = 14,
    parameter logic [63:0] SEED  = 64'h1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [OUT_W-1:0] uni
);
    logic [LEN-1:0] st;

    // Advance the register by STEPS single-bit shifts.
    function automatic logic [LEN-1:0] step_n(input logic [LEN-1:0] s);
        logic [LEN-1:0] t;
        t = s;
        for (int i = 0; i < STEPS; i++) begin
            t = {t[LEN-2:0], t[LEN-1] ^ t[TAP-1]};
        end
        return t;
    endfunction

    // State update: load the seed on reset, advance on each strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)   st <= SEED[LEN-1:0];
        else if (adv) st <= step_n(st);
    end

    assign uni = st[OUT_W-1:0];

    // R7: the register must never lock up in the all-zero state
    p_lfsr_live_r7: assert property (@(posedge clk) disable iff (!rst_n)
        st != '0);
endmodule

// File: rtl/sdm_tpdf.sv
// Triangular-PDF dither source.
// It subtracts the uniform outputs of two independent shift registers, giving a value in (-2^DW, 2^DW).
// The value is zero when disabled; the registers advance on every strobe either way.
module sdm_tpdf #(
    parameter int DW = sdm_pkg::SDM_STEP_LOG2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                adv,
    input  logic                en,
    output logic signed [DW:0]  dith
);
    localparam int NSRC = 2;
    logic [DW-1:0] uni [NSRC];

    // Two sources with distinct polynomials and seeds.
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        localparam int          LEN_G = (g == 0) ? 31 : 23;
        localparam int          TAP_G = (g == 0) ? 28 : 18;
        localparam logic [63:0] SEED_G = (g == 0) ? 64'h2A5C_3B17 : 64'h004F_1E29;
        sdm_lfsr #(
            .LEN(LEN_G), .TAP(TAP_G), .STEPS(DW), .OUT_W(DW), .SEED(SEED_G)
        ) u_lfsr (
            .clk(clk), .rst_n(rst_n), .adv(adv), .uni(uni[g])
        );
    end

    // Difference of the two uniform values, gated by the enable.
    always_comb begin
        if (en) dith = $signed({1'b0, uni[0]}) - $signed({1'b0, uni[1]});
        else    dith = '0;
    end
endmodule

// File: rtl/sdm_quant.sv
// Seventeen-level mid-tread quantiser.
// It rounds v / 2^SL half-up, offsets the result by the mid code, clamps it to the code range,
// and also returns the signed level that the code stands for.
module sdm_quant
    import sdm_pkg::*;
#(
    parameter int AW = SDM_ACC_W,
    parameter int SL = SDM_STEP_LOG2
) (
    input  logic signed [AW-1:0] v,
    output sdm_code_t            code,
    output logic signed [AW-1:0] level
);
    localparam logic signed [AW-1:0] HALF = AW'(1) <<< (SL - 1);
    localparam logic signed [AW-1:0] MIDV = AW'(SDM_MID);

    logic signed [AW-1:0] t;
    logic signed [AW-1:0] q;
    logic signed [AW-1:0] cz;

    // Round, offset and clamp to 0..LEVELS-1.
    always_comb begin
        t = v + HALF;
        q = t >>> SL;
        if (q < -MIDV)     code = '0;
        else if (q > MIDV) code = SDM_CODE_W'(SDM_LEVELS - 1);
        else               code = SDM_CODE_W'(q + MIDV);
        cz    = AW'(code);
        level = (cz - MIDV) <<< SL;
    end
endmodule

// File: rtl/sdm_eloop.sv
// Second-order error-feedback noise shaper, NTF = (1 - z^-1)^2.
// On each strobe it computes w = x - 2*e1 + e2, quantises w plus dither, and stores
// e = level - w saturated to +-ELIM. The code is registered, so it appears one cycle after the strobe.
module sdm_eloop
    import sdm_pkg::*;
#(
    parameter int IN_W = SDM_IN_W,
    parameter int SL   = SDM_STEP_LOG2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic signed [IN_W-1:0] x,
    input  logic signed [SL:0]    dith,
    output logic                  out_valid,
    output sdm_code_t             code
);
    localparam int AW = IN_W + 4;
    localparam logic signed [AW-1:0] ELIM = AW'(2) <<< SL;

    logic signed [AW-1:0] e1, e2;
    logic signed [AW-1:0] w, v, lvl, e_raw, e_sat;
    sdm_code_t            q_code;

    sdm_quant #(.AW(AW), .SL(SL)) u_quant (
        .v(v), .code(q_code), .level(lvl)
    );

    // Loop value, dithered quantiser input and saturated new error.
    always_comb begin
        w     = AW'(x) - (e1 <<< 1) + e2;
        v     = w + AW'(dith);
        e_raw = lvl - w;
        if (e_raw > ELIM)       e_sat = ELIM;
        else if (e_raw < -ELIM) e_sat = -ELIM;
        else                    e_sat = e_raw;
    end

    // Error history and output registers; updated only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            e1        <= '0;
            e2        <= '0;
            code      <= SDM_CODE_W'(SDM_MID);
            out_valid <= 1'b0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                e1   <= e_sat;
                e2   <= e1;
                code <= q_code;
            end
        end
    end

    // R2: the code holds between strobes
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(code));
    // R5: a quiet loop with zero input and no dither gives the mid code
    p_zero_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && x == '0 && dith == '0 && e1 == '0 && e2 == '0)
        |=> code == SDM_CODE_W'(SDM_MID));
    // R4: the stored error never exceeds its saturation bound
    p_err_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (e1 <= ELIM) && (e1 >= -ELIM) && (e2 <= ELIM) && (e2 >= -ELIM));
endmodule

// File: rtl/msdm_core.sv
// One channel of the seventeen-level dithered modulator.
// It applies mute to the sample, draws dither on each strobe, and feeds both into the
// error-feedback loop. Assumes in_valid pulses at the oversampled rate.
module msdm_core
    import sdm_pkg::*;
#(
    parameter int IN_W = SDM_IN_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic signed [IN_W-1:0] in_sample,
    input  logic                   mute,
    input  logic                   dither_en,
    output logic                   out_valid,
    output logic [SDM_CODE_W-1:0]  out_code
);
    localparam int SL = IN_W - $clog2(SDM_LEVELS - 1);

    logic signed [IN_W-1:0] x_eff;
    logic signed [SL:0]     dith;

    // Mute replaces the sample with zero but leaves the loop running.
    always_comb x_eff = mute ? '0 : in_sample;

    sdm_tpdf #(.DW(SL)) u_tpdf (
        .clk(clk), .rst_n(rst_n), .adv(in_valid), .en(dither_en), .dith(dith)
    );

    sdm_eloop #(.IN_W(IN_W), .SL(SL)) u_loop (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .x(x_eff),
        .dith(dith), .out_valid(out_valid), .code(out_code)
    );

    // R3: code never leaves the level range
    p_code_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        out_code <= SDM_CODE_W'(SDM_LEVELS - 1));
    // R2: a strobe is answered in the next cycle
    p_valid_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    // R2: no output strobe without an input strobe
    p_valid_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
endmodule

// File: tb/msdm_core_tb.sv
module msdm_core_tb;
    localparam int CLK_P = 10;
    localparam longint STEP = 16384;
    localparam longint ELIM = 32768;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        in_valid = 0;
    logic signed [17:0] in_sample = '0;
    logic        mute = 0;
    logic        dither_en = 0;
    logic        out_valid;
    logic [4:0]  out_code;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    longint m_e1, m_e2;
    longint lvl_sum;
    int     min_code, max_code, non_mid;

    msdm_core u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
        .mute(mute), .dither_en(dither_en), .out_valid(out_valid), .out_code(out_code)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Expected code for one strobe with dither off, following the R4 rule.
    function automatic int model_step(input longint x);
        longint w, q, c, e;
        w = x - 2*m_e1 + m_e2;
        q = (w + STEP/2) >>> 14;
        c = q + 8;
        if (c < 0) c = 0;
        if (c > 16) c = 16;
        e = (c - 8)*STEP - w;
        if (e > ELIM) e = ELIM;
        if (e < -ELIM) e = -ELIM;
        m_e2 = m_e1;
        m_e1 = e;
        return int'(c);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; in_valid = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_e1 = 0; m_e2 = 0;
        lvl_sum = 0; min_code = 16; max_code = 0; non_mid = 0;
    endtask

    // Send one sample; check valid timing, the code (if exact) and the hold over a random gap.
    task automatic send(input longint x, input bit exact, input longint x_model,
                        input string req);
        int exp_c, got, gap;
        in_valid = 1; in_sample = 18'(x);
        @(negedge clk);
        in_valid = 0;
        chk(out_valid === 1'b1, "R2", "out_valid after strobe", longint'(out_valid), 1);
        got = int'(out_code);
        exp_c = model_step(x_model);
        if (exact) chk(got == exp_c, req, "code", got, exp_c);
        chk(got <= 16, "R3", "code range", got, 16);
        lvl_sum += (longint'(got) - 8) * STEP;
        if (got < min_code) min_code = got;
        if (got > max_code) max_code = got;
        if (got != 8) non_mid++;
        gap = int'($urandom % 3);
        for (int i = 0; i < gap; i++) begin
            @(negedge clk);
            chk(out_valid === 1'b0 && int'(out_code) == got, "R2", "hold between strobes",
                longint'(out_code), got);
        end
    endtask

    task automatic const_run(input longint x, input bit dith, input int n);
        longint diff;
        do_reset();
        dither_en = dith;
        for (int i = 0; i < n; i++) send(x, !dith, x, "R4");
        diff = lvl_sum - longint'(n) * x;
        if (diff < 0) diff = -diff;
        chk(diff <= 4*ELIM, "R6", "sum deviation", diff, 4*ELIM);
        dither_en = 0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R1: reset state
        chk(out_valid === 1'b0, "R1", "out_valid after reset", longint'(out_valid), 0);
        chk(out_code == 5'd8, "R1", "code after reset", longint'(out_code), 8);

        // R5: zero input, dither off
        for (int i = 0; i < 64; i++) send(0, 1, 0, "R5");
        chk(non_mid == 0, "R5", "non-mid codes on zero input", non_mid, 0);

        // R4: random full-range samples, exact model
        do_reset();
        for (int i = 0; i < 300; i++) begin
            longint x;
            x = longint'($signed(18'($urandom)));
            send(x, 1, x, "R4");
        end
        // R8: mute mid-run continues the loop from its state with zero input
        mute = 1;
        for (int i = 0; i < 100; i++) begin
            longint x;
            x = longint'($signed(18'($urandom)));
            send(x, 1, 0, "R8");
        end
        mute = 0;

        // R9: full-scale positive and negative
        do_reset();
        for (int i = 0; i < 40; i++) send(131071, 1, 131071, "R9");
        chk(max_code == 16, "R9", "positive clamp reached", max_code, 16);
        for (int i = 0; i < 40; i++) send(-131072, 1, -131072, "R9");
        chk(min_code == 0, "R9", "negative clamp reached", min_code, 0);

        // R6: constant inputs with and without dither
        const_run(12345, 0, 1024);
        const_run(-20000, 0, 1024);
        const_run(30000, 1, 1024);
        const_run(-32768, 1, 1024);
        const_run(777, 1, 1024);

        // R7: dither on zero input stays in 2..14 and is not constant
        do_reset();
        dither_en = 1;
        for (int i = 0; i < 512; i++) send(0, 0, 0, "R7");
        chk(min_code >= 2, "R7", "min dithered code", min_code, 2);
        chk(max_code <= 14, "R7", "max dithered code", max_code, 14);
        chk(non_mid > 0, "R7", "dither moves the code", non_mid, 1);
        dither_en = 0;

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_P * 190000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule